// File: doc/BRIEF.md
# Morphology array instruction sequencer

This block is the control unit of a reconfigurable array of morphology processing elements. After a start pulse it reads 24-bit instructions one at a time from a small synchronous instruction memory, beginning at address 0. Each instruction is decoded and carried out. An instruction can load the configuration word of one or more processing elements, write the array's two threshold registers, blank the rest of the array, or run frames through the array.

A write pointer walks along the chain of elements. One configuration instruction can give the same setting to several consecutive elements through a repeat count. A blanking instruction fills every element from the pointer to the end with the no-operation setting and then rewinds the pointer to element 0. Frame passes are requested from the streaming logic with a one-cycle pulse, and the sequencer waits for that logic to report the pass as finished. In the iterate mode the sequencer samples a changed flag at the end of each pass and runs another pass while the flag is set, up to a parameterised limit.

The program ends at an exit instruction. The sequencer then raises done and holds it until the next start.

Top module: `morph_seq`

## Requirements
- R1: After reset the block is idle with busy, done, err, cfg_we, thr_we, pass_start and imem_en all low. A start pulse makes it fetch instructions from address 0 upward. The opcode is instruction bits [23:21] and the operand is bits [20:0].
- R2: Opcode 001 (single-pass configure) writes operand bits [20:6] as cfg_data to consecutive elements starting at the pointer, one element per cycle with cfg_idx equal to the pointer. It then issues exactly one frame pass. The cfg_data layout is {upper op [14:11], lower op [10:7], wide mode [6], routing [5:0]}.
- R3: The repeat count is instruction bits [5:0]. A count of 0 programs one element. Writes stop at element NUM_PE-1, so cfg_idx is never NUM_PE or more, and the extra count is dropped.
- R4: Opcode 010 (iterate until stable) programs exactly one element and ignores the count. It then issues passes as long as pass_changed is high when pass_done arrives. It stops after MAX_ITER passes at most.
- R5: Opcode 011 raises thr_we for one cycle with thr_a equal to bits [15:8] and thr_b equal to bits [7:0]. It issues no configuration write and no pass.
- R6: Opcode 100 writes cfg_data of all zeros to every element from the pointer up to NUM_PE-1. It then sets the pointer to 0, so the next configuration write goes to element 0.
- R7: Opcode 000 ends the program. done stays high and busy stays low until the next start. That start restarts at address 0 with the pointer at element 0.
- R8: Opcodes 101, 110 and 111 end the program in the same way as 000 and also set err. err stays set until the next start clears it.
- R9: pass_start is a single-cycle pulse and no second pass is requested before pass_done arrives. At most one of cfg_we, thr_we, pass_start and imem_en is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted while idle or halted |
| busy | output | 1 | Program running |
| done | output | 1 | Program ended; held until next start |
| err | output | 1 | Program ended on an unused opcode |
| imem_en | output | 1 | Instruction memory read enable |
| imem_addr | output | $clog2(IMEM_DEPTH) | Instruction address |
| imem_rdata | input | 24 | Instruction word, one cycle after imem_en |
| cfg_we | output | 1 | Element configuration write strobe |
| cfg_idx | output | $clog2(NUM_PE+1) | Element index being written |
| cfg_data | output | 15 | Element configuration word |
| thr_we | output | 1 | Threshold write strobe |
| thr_a | output | 8 | First threshold value |
| thr_b | output | 8 | Second threshold value |
| pass_start | output | 1 | Request one frame pass through the array |
| pass_done | input | 1 | Frame pass finished |
| pass_changed | input | 1 | Last pass changed the frame; sampled with pass_done |

## Verification
Directed programs cover the following cases:
- A repeat count of 3, a count of 0 and a count of 12 from element 1. These separate correct counting from the zero-means-one rule and from clipping at the end of the array.
- A blank issued after three elements, then one more configuration. This shows whether the tail is blanked and whether the pointer really rewinds.
- Iterate instructions whose changed-flag sequences stop the loop after three passes, or never stop it. These separate the stable exit from the iteration limit.
- A program that ends on an unused opcode, and a program run twice in a row, to cover the error flag and the restart.

Seeded random programs then mix all five instruction kinds with random operands and random changed flags. A reference model in the bench replays each program and predicts the configuration writes, threshold writes and pass counts.

// File: rtl/morph_seq_pkg.sv
package morph_seq_pkg;

  localparam int INSTR_W = 24;
  localparam int CFG_W   = 15;

  localparam logic [2:0] OPC_EXT = 3'd0;
  localparam logic [2:0] OPC_NOR = 3'd1;
  localparam logic [2:0] OPC_LUN = 3'd2;
  localparam logic [2:0] OPC_STH = 3'd3;
  localparam logic [2:0] OPC_CPE = 3'd4;

  typedef struct packed {
    logic [3:0] op_hi;
    logic [3:0] op_lo;
    logic       wide;
    logic [5:0] route;
  } pe_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_LOAD,
    S_DECODE,
    S_CFG,
    S_THR,
    S_BLANK,
    S_PASS,
    S_WAIT,
    S_HALT
  } seq_state_t;

endpackage

// File: rtl/morph_seq_decode.sv
module morph_seq_decode
  import morph_seq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               is_ext,
  output logic               is_bad,
  output logic               is_nor,
  output logic               is_lun,
  output logic               is_sth,
  output logic               is_cpe,
  output pe_cfg_t            cfg,
  output logic [5:0]         rep_eff,
  output logic [7:0]         thr_hi,
  output logic [7:0]         thr_lo
);

  logic [2:0] opc;

  always_comb begin
    opc     = instr[23:21];
    is_ext  = (opc == OPC_EXT);
    is_nor  = (opc == OPC_NOR);
    is_lun  = (opc == OPC_LUN);
    is_sth  = (opc == OPC_STH);
    is_cpe  = (opc == OPC_CPE);
    is_bad  = (opc > OPC_CPE);
    cfg     = pe_cfg_t'(instr[20:6]);
    rep_eff = (instr[5:0] == 6'd0) ? 6'd1 : instr[5:0];
    thr_hi  = instr[15:8];
    thr_lo  = instr[7:0];
  end

endmodule

// File: rtl/morph_seq_ptr.sv
module morph_seq_ptr #(
  parameter int NUM_PE = 8,
  localparam int PW = $clog2(NUM_PE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          at_end
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = clr | (adv & ~at_end);
    ptr_d  = clr ? '0 : ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr    = ptr_q;
  assign at_end = (ptr_q == PW'(NUM_PE));

endmodule

// File: rtl/morph_seq_iter.sv
module morph_seq_iter #(
  parameter int MAX_ITER = 16,
  localparam int CW = $clog2(MAX_ITER + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic limit_hit
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    limit_hit = (cnt_q >= CW'(MAX_ITER));
    cnt_en    = clr | (inc & ~limit_hit);
    cnt_d     = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/morph_seq.sv
module morph_seq
  import morph_seq_pkg::*;
#(
  parameter int IMEM_DEPTH = 32,
  parameter int NUM_PE     = 8,
  parameter int MAX_ITER   = 16,
  localparam int AW = $clog2(IMEM_DEPTH),
  localparam int PW = $clog2(NUM_PE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               imem_en,
  output logic [AW-1:0]      imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic               cfg_we,
  output logic [PW-1:0]      cfg_idx,
  output logic [CFG_W-1:0]   cfg_data,
  output logic               thr_we,
  output logic [7:0]         thr_a,
  output logic [7:0]         thr_b,
  output logic               pass_start,
  input  logic               pass_done,
  input  logic               pass_changed
);

  seq_state_t         state_q, state_d;
  logic [AW-1:0]      pc_q, pc_d;
  logic [INSTR_W-1:0] ir_q;
  logic [5:0]         rem_q, rem_d;
  logic               err_q, err_d;
  logic               ir_en;

  logic    d_ext, d_bad, d_nor, d_lun, d_sth, d_cpe;
  pe_cfg_t d_cfg;
  logic [5:0] d_rep;
  logic [7:0] d_thr_hi, d_thr_lo;

  logic          ptr_clr, ptr_adv, at_end;
  logic [PW-1:0] ptr;
  logic          iter_clr, iter_inc, limit_hit;
  logic          blank_sel;

  morph_seq_decode u_dec (
    .instr   (ir_q),
    .is_ext  (d_ext),
    .is_bad  (d_bad),
    .is_nor  (d_nor),
    .is_lun  (d_lun),
    .is_sth  (d_sth),
    .is_cpe  (d_cpe),
    .cfg     (d_cfg),
    .rep_eff (d_rep),
    .thr_hi  (d_thr_hi),
    .thr_lo  (d_thr_lo)
  );

  morph_seq_ptr #(.NUM_PE(NUM_PE)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ptr_clr),
    .adv    (ptr_adv),
    .ptr    (ptr),
    .at_end (at_end)
  );

  morph_seq_iter #(.MAX_ITER(MAX_ITER)) u_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (iter_clr),
    .inc       (iter_inc),
    .limit_hit (limit_hit)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    rem_d      = rem_q;
    err_d      = err_q;
    ir_en      = 1'b0;
    imem_en    = 1'b0;
    cfg_we     = 1'b0;
    thr_we     = 1'b0;
    pass_start = 1'b0;
    ptr_clr    = 1'b0;
    ptr_adv    = 1'b0;
    iter_clr   = 1'b0;
    iter_inc   = 1'b0;
    blank_sel  = 1'b0;
    unique case (state_q)
      S_IDLE, S_HALT: begin
        if (start) begin
          pc_d    = '0;
          err_d   = 1'b0;
          ptr_clr = 1'b1;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        imem_en = 1'b1;
        state_d = S_LOAD;
      end
      S_LOAD: begin
        ir_en   = 1'b1;
        state_d = S_DECODE;
      end
      S_DECODE: begin
        iter_clr = 1'b1;
        if (d_nor || d_lun) begin
          rem_d   = d_lun ? 6'd1 : d_rep;
          state_d = S_CFG;
        end else if (d_sth) begin
          state_d = S_THR;
        end else if (d_cpe) begin
          state_d = S_BLANK;
        end else begin
          err_d   = d_bad;
          state_d = S_HALT;
        end
      end
      S_CFG: begin
        if ((rem_q != 6'd0) && !at_end) begin
          cfg_we  = 1'b1;
          ptr_adv = 1'b1;
          rem_d   = rem_q - 6'd1;
        end else begin
          state_d = S_PASS;
        end
      end
      S_THR: begin
        thr_we  = 1'b1;
        pc_d    = pc_q + AW'(1);
        state_d = S_FETCH;
      end
      S_BLANK: begin
        blank_sel = 1'b1;
        if (!at_end) begin
          cfg_we  = 1'b1;
          ptr_adv = 1'b1;
        end else begin
          ptr_clr = 1'b1;
          pc_d    = pc_q + AW'(1);
          state_d = S_FETCH;
        end
      end
      S_PASS: begin
        pass_start = 1'b1;
        iter_inc   = 1'b1;
        state_d    = S_WAIT;
      end
      S_WAIT: begin
        if (pass_done) begin
          if (d_lun && pass_changed && !limit_hit) begin
            state_d = S_PASS;
          end else begin
            pc_d    = pc_q + AW'(1);
            state_d = S_FETCH;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      rem_q   <= rem_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= imem_rdata;
  end

  assign busy      = (state_q != S_IDLE) && (state_q != S_HALT);
  assign done      = (state_q == S_HALT);
  assign err       = err_q;
  assign imem_addr = pc_q;
  assign cfg_idx   = ptr;
  assign cfg_data  = blank_sel ? '0 : CFG_W'(d_cfg);
  assign thr_a     = d_thr_hi;
  assign thr_b     = d_thr_lo;

endmodule

// File: rtl/morph_seq_chk.sv
module morph_seq_chk #(
  parameter int NUM_PE = 8,
  localparam int PW = $clog2(NUM_PE + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          imem_en,
  input logic          cfg_we,
  input logic [PW-1:0] cfg_idx,
  input logic          thr_we,
  input logic          pass_start,
  input logic          pass_done
);

  logic pass_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pass_open <= 1'b0;
    else if (pass_start) pass_open <= 1'b1;
    else if (pass_done)  pass_open <= 1'b0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !imem_en && !cfg_we && !thr_we && !pass_start);

  p_idx_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_idx < PW'(NUM_PE)));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_pass_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start |=> !pass_start);

  p_one_pass_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_open |-> !pass_start);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_we, thr_we, pass_start, imem_en}));

endmodule

bind morph_seq morph_seq_chk #(.NUM_PE(NUM_PE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .imem_en    (imem_en),
  .cfg_we     (cfg_we),
  .cfg_idx    (cfg_idx),
  .thr_we     (thr_we),
  .pass_start (pass_start),
  .pass_done  (pass_done)
);

// File: tb/morph_seq_tb_top.sv
module morph_seq_tb_top;

  localparam int DEPTH = 32;
  localparam int NPE   = 8;
  localparam int MAXI  = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(NPE + 1);
  localparam int LOGN  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, err, imem_en, cfg_we, thr_we, pass_start;
  logic [AW-1:0] imem_addr;
  logic [23:0]   imem_rdata = '0;
  logic [PW-1:0] cfg_idx;
  logic [14:0]   cfg_data;
  logic [7:0]    thr_a, thr_b;
  logic pass_done = 1'b0;
  logic pass_changed = 1'b0;

  always #10 clk = ~clk;

  morph_seq #(.IMEM_DEPTH(DEPTH), .NUM_PE(NPE), .MAX_ITER(MAXI)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .thr_we(thr_we), .thr_a(thr_a), .thr_b(thr_b),
    .pass_start(pass_start), .pass_done(pass_done), .pass_changed(pass_changed)
  );

  logic [23:0] mem [DEPTH];
  logic [63:0] chg;
  int vectors = 0;
  int fails = 0;

  // memory model
  always @(posedge clk) if (imem_en) imem_rdata <= mem[imem_addr];

  // frame pass responder
  int dly = 0;
  int pidx = 0;
  always @(posedge clk) begin
    pass_done <= 1'b0;
    if (start) pidx <= 0;
    if (pass_start) dly <= 3;
    else if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        pass_done    <= 1'b1;
        pass_changed <= chg[pidx % 64];
        pidx         <= pidx + 1;
      end
    end
  end

  // observed logs
  int n_cfg, n_thr, n_pass;
  int lc_idx [LOGN];
  int lc_dat [LOGN];
  int lt_val [LOGN];
  always @(negedge clk) begin
    if (cfg_we && n_cfg < LOGN) begin
      lc_idx[n_cfg] = int'(cfg_idx);
      lc_dat[n_cfg] = int'(cfg_data);
      n_cfg++;
    end
    if (thr_we && n_thr < LOGN) begin
      lt_val[n_thr] = int'({thr_a, thr_b});
      n_thr++;
    end
    if (pass_start) n_pass++;
  end

  // expected logs
  int e_cfg, e_thr, e_pass, e_err;
  int ec_idx [LOGN];
  int ec_dat [LOGN];
  int et_val [LOGN];

  function automatic logic [23:0] mk(input logic [2:0] op, input logic [14:0] c, input logic [5:0] cnt);
    return {op, c, cnt};
  endfunction

  function automatic logic [23:0] mk_thr(input logic [7:0] a, input logic [7:0] b);
    return {3'd3, 5'd0, a, b};
  endfunction

  task automatic push_cfg(input int idx, input int dat);
    if (e_cfg < LOGN) begin
      ec_idx[e_cfg] = idx;
      ec_dat[e_cfg] = dat;
    end
    e_cfg++;
  endtask

  // reference model built from the requirements
  task automatic model_run();
    int pc = 0;
    int ptr = 0;
    int pi = 0;
    bit fin = 0;
    e_cfg = 0; e_thr = 0; e_pass = 0; e_err = 0;
    while (!fin && pc < DEPTH) begin
      logic [23:0] ins = mem[pc];
      int op = int'(ins[23:21]);
      case (op)
        1: begin
          int n = (ins[5:0] == 0) ? 1 : int'(ins[5:0]);
          for (int k = 0; k < n; k++)
            if (ptr < NPE) begin push_cfg(ptr, int'(ins[20:6])); ptr++; end
          e_pass++; pi++;
          pc++;
        end
        2: begin
          int it = 0;
          bit c;
          if (ptr < NPE) begin push_cfg(ptr, int'(ins[20:6])); ptr++; end
          do begin
            it++;
            c = chg[pi % 64];
            pi++;
            e_pass++;
          end while (c && it < MAXI);
          pc++;
        end
        3: begin
          if (e_thr < LOGN) et_val[e_thr] = int'(ins[15:0]);
          e_thr++;
          pc++;
        end
        4: begin
          while (ptr < NPE) begin push_cfg(ptr, 0); ptr++; end
          ptr = 0;
          pc++;
        end
        default: begin
          e_err = (op >= 5) ? 1 : 0;
          fin = 1;
        end
      endcase
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_prog(input string tag);
    int cyc = 0;
    model_run();
    n_cfg = 0; n_thr = 0; n_pass = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R7 done reached"}, int'(done), 1);
    chk({tag, " R7 busy low at end"}, int'(busy), 0);
    chk({tag, " R8 err"}, int'(err), e_err);
    chk({tag, " R2 cfg write count"}, n_cfg, e_cfg);
    for (int i = 0; i < e_cfg && i < n_cfg && i < LOGN; i++) begin
      chk({tag, " R3 cfg index"}, lc_idx[i], ec_idx[i]);
      chk({tag, " R6 cfg data"}, lc_dat[i], ec_dat[i]);
    end
    chk({tag, " R5 thr write count"}, n_thr, e_thr);
    for (int i = 0; i < e_thr && i < n_thr && i < LOGN; i++)
      chk({tag, " R5 thr values"}, lt_val[i], et_val[i]);
    chk({tag, " R4 pass count"}, n_pass, e_pass);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  // watchdog
  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    chg = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset err", int'(err), 0);
    chk("R1 reset strobes", int'({cfg_we, thr_we, pass_start, imem_en}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", int'({busy, done}), 0);

    // R2/R3: count 3, count 0, threshold, exit
    clear_mem();
    mem[0] = mk(3'd1, 15'h1234, 6'd3);
    mem[1] = mk(3'd1, 15'h0abc, 6'd0);
    mem[2] = mk_thr(8'h5a, 8'hc3);
    mem[3] = '0;
    run_prog("dir1 R2 R3 R5");

    // R7: same program again starts at element 0
    run_prog("dir1 rerun R7");
    repeat (5) @(negedge clk);
    chk("R7 done held while idle", int'(done), 1);

    // R3 clip: one element, then count 12 clipped, then iterate on full array
    clear_mem();
    chg = 64'h0;
    mem[0] = mk(3'd1, 15'h7001, 6'd1);
    mem[1] = mk(3'd1, 15'h2222, 6'd12);
    mem[2] = mk(3'd2, 15'h3333, 6'd9);
    run_prog("dir2 R3 clip");

    // R6: blank after three, then one more element goes to index 0
    clear_mem();
    mem[0] = mk(3'd1, 15'h4444, 6'd3);
    mem[1] = {3'd4, 21'h0};
    mem[2] = mk(3'd1, 15'h5555, 6'd1);
    run_prog("dir3 R6 blank");

    // R4: stable after three passes, then never stable
    clear_mem();
    chg = 64'h0000_0000_0000_0003;
    mem[0] = mk(3'd2, 15'h6666, 6'd5);
    run_prog("dir4 R4 stable");
    chg = '1;
    run_prog("dir5 R4 limit");

    // R8: unused opcode ends with error, then a clean run clears it
    clear_mem();
    mem[0] = mk(3'd1, 15'h0011, 6'd2);
    mem[1] = {3'd6, 21'h1abcde};
    mem[2] = mk(3'd1, 15'h0022, 6'd2);
    run_prog("dir6 R8 bad opcode");
    clear_mem();
    mem[0] = mk_thr(8'h01, 8'h02);
    run_prog("dir7 R8 err cleared");

    // random programs
    for (int r = 0; r < 40; r++) begin
      int len = 1 + int'($urandom % 10);
      clear_mem();
      chg = {$urandom, $urandom};
      for (int i = 0; i < len; i++) begin
        logic [2:0] op = 3'd1 + 3'($urandom % 4);
        mem[i] = {op, 21'($urandom)};
      end
      mem[len] = ($urandom % 4 == 0) ? {3'd5 + 3'($urandom % 3), 21'($urandom)} : 24'h0;
      run_prog("rand R2 R4 R6");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule